// File: doc/BRIEF.md
# Depthwise 3x3 Convolution Engine

This engine runs one depthwise convolution layer over a channel-first feature map held in external memory. The controller loads a layer description (input side length, channel count, stride code, batch-norm and ReLU enables, and three base addresses) and pulses `start`. For each channel the engine first fetches that channel's parameter block. It then walks the output grid in raster order. For each output pixel it fetches the nine pixels of the 3x3 window and combines them with the channel's nine weights, using nine parallel multipliers that feed one adder.

Each result is shaped by optional batch-norm and ReLU. It is then pushed into a 16-entry output queue, together with its destination address. The queue drains to memory through a separate write port whenever that port signals it can take a word. The input is already padded in memory, so the engine computes valid positions only. When every channel is finished and the queue is empty, the engine holds `done` until the next start.

Top module: `dw3x3_engine`

## Requirements
- R1: The output side length is (size-3)/stride+1. The stride is 2 when bit 1 of `cfg_stride` is set (code 2) and 1 otherwise (code 0). Window rows and columns start at the output row and column times the stride.
- R2: Values are signed Q8.8 in the low 16 bits of a word. A result is the sum of the nine pixel×weight products, shifted right arithmetically by 8 (rounding toward minus infinity) and saturated to the range 0x8000..0x7FFF.
- R3: Channel c takes its parameters from the 11 consecutive words at `cfg_wt_base`+11·c. Word 3·ky+kx holds the weight for kernel row ky and column kx. Word 9 holds the batch-norm scale and word 10 holds the bias. Only that channel's own weights are used.
- R4: The input pixel (c,y,x) is read at `cfg_in_base`+c·size²+y·size+x. The upper 16 bits of every read word are ignored.
- R5: With `cfg_bn` set, the convolution result v becomes sat16(((v·scale)>>>8)+bias).
- R6: With `cfg_relu` set, negative values become 0. This step is applied after batch-norm.
- R7: Output (c,oy,ox) is written exactly once, at `cfg_out_base`+c·o²+oy·o+ox, as the 16-bit result sign-extended to 32 bits.
- R8: `rd_req` and `rd_addr` stay fixed until `rd_gnt`. Only one read is outstanding, and its data is taken when `rd_valid` is high.
- R9: `wr_req`, `wr_addr` and `wr_data` stay fixed until `wr_ready`. The queue holds 16 results. While it is full, no new window read starts. With writes blocked from the start of a layer, the engine issues exactly 11+9·16 reads and then waits with no result lost.
- R10: `done` rises only after the last write is accepted and the queue is empty. It stays high with `busy` low until the next `start`, which clears it and raises `busy` on the next cycle.
- R11: A `start` pulse while `busy` is high is ignored. The running layer completes with its original configuration.
- R12: After reset, `busy`, `done`, `rd_req` and `wr_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a layer (taken when not busy) |
| cfg_size | input | SW | Input side length, padded, at least 3 |
| cfg_chan | input | CW | Channel count, at least 1 |
| cfg_stride | input | 2 | Stride code: 0 gives stride 1, 2 gives stride 2 |
| cfg_bn | input | 1 | Enable batch-norm scale and bias |
| cfg_relu | input | 1 | Enable ReLU |
| cfg_in_base | input | AW | Input feature map base address |
| cfg_out_base | input | AW | Output feature map base address |
| cfg_wt_base | input | AW | Parameter block base address |
| busy | output | 1 | Layer in progress |
| done | output | 1 | Layer finished, held until next start |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read word address |
| rd_gnt | input | 1 | Read request accepted |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | DW | Read data |
| wr_req | output | 1 | Write request (queue not empty) |
| wr_addr | output | AW | Write word address |
| wr_data | output | DW | Write data |
| wr_ready | input | 1 | Write accepted this cycle |

## Verification
The assertions assume a well-behaved memory side. `rd_valid` arrives only in a later cycle than the grant of the single outstanding read, and the configuration gives a size of at least 3 and a channel count of at least 1. The bench memory model raises `rd_valid` exactly one cycle after each accepted read. It varies grant and write-ready patterns independently of each other. Every layer it runs uses a legal size and channel count, with addresses that fall inside the modelled memory.

// File: rtl/dw3x3_engine.sv
module dw3x3_engine #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SW    = 8,
  parameter int CW    = 11,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [SW-1:0] cfg_size,
  input  logic [CW-1:0] cfg_chan,
  input  logic [1:0]    cfg_stride,
  input  logic          cfg_bn,
  input  logic          cfg_relu,
  input  logic [AW-1:0] cfg_in_base,
  input  logic [AW-1:0] cfg_out_base,
  input  logic [AW-1:0] cfg_wt_base,
  output logic          busy,
  output logic          done,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_gnt,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ready
);
  localparam int PW   = $clog2(DEPTH);
  localparam int NPAR = 11;
  localparam int NTAP = 9;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_PUSH, S_DRAIN, S_DONE} st_t;

  function automatic logic signed [15:0] sat16(input logic signed [39:0] v);
    if (v > 40'sd32767)  return 16'sh7FFF;
    if (v < -40'sd32768) return 16'sh8000;
    return v[15:0];
  endfunction

  st_t st;
  logic [SW-1:0] sz, oy, ox;
  logic [CW-1:0] nch, ch;
  logic          two, bn, relu, pmode;
  logic [AW-1:0] in_b, wt_b, optr;
  logic [3:0]    k;
  logic signed [15:0] px [NTAP];
  logic signed [15:0] wt [NTAP];
  logic signed [15:0] scl, bia;
  logic [15:0]   fdat [DEPTH];
  logic [AW-1:0] fadr [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;

  wire [SW-1:0] osz = two ? SW'((sz - SW'(3)) >> 1) + SW'(1) : sz - SW'(2);
  wire [1:0] ky = (k >= 4'd6) ? 2'd2 : (k >= 4'd3) ? 2'd1 : 2'd0;
  wire [1:0] kx = 2'(k - 4'(ky) * 4'd3);

  wire [AW-1:0] plane    = AW'(sz) * AW'(sz);
  wire [AW-1:0] row      = (AW'(oy) << two) + AW'(ky);
  wire [AW-1:0] col      = (AW'(ox) << two) + AW'(kx);
  wire [AW-1:0] px_addr  = in_b + AW'(ch) * plane + row * AW'(sz) + col;
  wire [AW-1:0] par_addr = wt_b + AW'(ch) * AW'(NPAR) + AW'(k);

  wire full     = cnt == (PW+1)'(DEPTH);
  wire win_hold = !pmode && k == 4'd0 && full;
  wire push     = (st == S_PUSH) && !full;
  wire pop      = wr_req && wr_ready;
  wire last_x   = ox == osz - SW'(1);
  wire last_y   = oy == osz - SW'(1);
  wire last_c   = ch == nch - CW'(1);
  wire unused_hi = ^rd_data[DW-1:16];

  assign rd_req  = (st == S_REQ) && !win_hold;
  assign rd_addr = pmode ? par_addr : px_addr;
  assign wr_req  = cnt != '0;
  assign wr_addr = fadr[rp];
  assign wr_data = {{(DW-16){fdat[rp][15]}}, fdat[rp]};
  assign busy    = st inside {S_REQ, S_WAIT, S_PUSH, S_DRAIN};
  assign done    = st == S_DONE;

  logic signed [35:0] acc;
  logic signed [31:0] m;
  logic signed [15:0] cv, bv, res;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NTAP; i++)
      acc = acc + 36'(32'(px[i]) * 32'(wt[i]));
    cv  = sat16(40'(acc >>> 8));
    m   = 32'(cv) * 32'(scl);
    bv  = sat16(40'(m >>> 8) + 40'(bia));
    res = bn ? bv : cv;
    if (relu && res < 0) res = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sz <= '0; nch <= '0; ch <= '0; oy <= '0; ox <= '0;
      two <= 1'b0; bn <= 1'b0; relu <= 1'b0; pmode <= 1'b1;
      in_b <= '0; wt_b <= '0; optr <= '0; k <= '0;
      scl <= '0; bia <= '0;
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) begin
        fdat[wp] <= res;
        fadr[wp] <= optr;
        wp       <= wp + 1'b1;
        optr     <= optr + 1'b1;
      end
      if (pop) rp <= rp + 1'b1;
      cnt <= cnt + (PW+1)'(push) - (PW+1)'(pop);

      case (st)
        S_IDLE, S_DONE: if (start) begin
          sz <= cfg_size; nch <= cfg_chan; two <= cfg_stride[1];
          bn <= cfg_bn; relu <= cfg_relu;
          in_b <= cfg_in_base; wt_b <= cfg_wt_base; optr <= cfg_out_base;
          ch <= '0; oy <= '0; ox <= '0; k <= '0; pmode <= 1'b1;
          st <= S_REQ;
        end
        S_REQ: if (rd_req && rd_gnt) st <= S_WAIT;
        S_WAIT: if (rd_valid) begin
          if (pmode) begin
            if (k < 4'd9)       wt[k] <= rd_data[15:0];
            else if (k == 4'd9) scl   <= rd_data[15:0];
            else                bia   <= rd_data[15:0];
            if (k == 4'd10) begin
              pmode <= 1'b0;
              k     <= '0;
            end else k <= k + 4'd1;
            st <= S_REQ;
          end else begin
            px[k] <= rd_data[15:0];
            if (k == 4'd8) begin
              k  <= '0;
              st <= S_PUSH;
            end else begin
              k  <= k + 4'd1;
              st <= S_REQ;
            end
          end
        end
        S_PUSH: if (!full) begin
          if (last_x) begin
            ox <= '0;
            oy <= last_y ? '0 : oy + SW'(1);
          end else ox <= ox + SW'(1);
          if (last_x && last_y) begin
            if (last_c) st <= S_DRAIN;
            else begin
              ch    <= ch + CW'(1);
              pmode <= 1'b1;
              st    <= S_REQ;
            end
          end else st <= S_REQ;
        end
        S_DRAIN: if (cnt == '0) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module dw3x3_engine_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   busy,
  input logic                   done,
  input logic                   rd_req,
  input logic                   rd_gnt,
  input logic [AW-1:0]          rd_addr,
  input logic                   wr_req,
  input logic                   wr_ready,
  input logic [AW-1:0]          wr_addr,
  input logic [DW-1:0]          wr_data,
  input logic [$clog2(DEPTH):0] fill
);
  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_gnt) |=> (rd_req && $stable(rd_addr)));

  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ready) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= DEPTH);

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !rd_req && !wr_req && fill == 0));

  // R10
  start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));

  // R11
  stay_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && rd_req) |=> busy);
endmodule

bind dw3x3_engine dw3x3_engine_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .rd_req(rd_req), .rd_gnt(rd_gnt), .rd_addr(rd_addr),
  .wr_req(wr_req), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .fill(cnt)
);

// File: tb/dw3x3_engine_tb.sv
module dw3x3_engine_tb;
  localparam int CLK_NS = 10;
  localparam int IN_B   = 1024;
  localparam int OUT_B  = 4096;
  // [31:24] size, [23:16] channels, [15:12] stride code, [11:8] bn, [7:4] relu, [3:0] write mode
  localparam logic [31:0] VEC [6] = '{
    32'h05_02_0_0_0_0, 32'h06_03_0_1_1_1, 32'h07_02_2_0_1_0,
    32'h08_01_2_1_0_1, 32'h03_04_0_0_0_0, 32'h0A_03_0_1_0_1 };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] cfg_size = 8'd3;
  logic [10:0] cfg_chan = 11'd1;
  logic [1:0] cfg_stride = 2'd0;
  logic cfg_bn = 1'b0, cfg_relu = 1'b0;
  logic [31:0] cfg_in_base = IN_B, cfg_out_base = OUT_B, cfg_wt_base = 0;
  logic busy, done, rd_req, rd_gnt, wr_req, wr_ready;
  logic rd_valid = 1'b0;
  logic [31:0] rd_addr, rd_data = '0, wr_addr, wr_data;
  logic [31:0] mem [8192];
  int cyc = 0, rd_cnt = 0, wr_cnt = 0, gmode = 0, wmode = 0;
  logic wr_hold = 1'b0;
  int total = 0, bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  dw3x3_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_size(cfg_size), .cfg_chan(cfg_chan),
    .cfg_stride(cfg_stride), .cfg_bn(cfg_bn), .cfg_relu(cfg_relu),
    .cfg_in_base(cfg_in_base), .cfg_out_base(cfg_out_base), .cfg_wt_base(cfg_wt_base),
    .busy(busy), .done(done), .rd_req(rd_req), .rd_addr(rd_addr), .rd_gnt(rd_gnt),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ready(wr_ready));

  assign rd_gnt   = (gmode == 0) ? 1'b1 : (cyc % 3 != 1);
  assign wr_ready = !wr_hold && (wmode == 0 || cyc % 4 == 0);

  always @(posedge clk) begin
    cyc      <= cyc + 1;
    rd_valid <= rd_req && rd_gnt;
    rd_data  <= mem[rd_addr[12:0]];
    if (rd_req && rd_gnt) rd_cnt <= rd_cnt + 1;
    if (wr_req && wr_ready) begin
      mem[wr_addr[12:0]] <= wr_data;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic longint sat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic logic [31:0] model(input int c, input int oy, input int ox,
                                        input int size, input int s, input bit bn, input bit relu);
    longint acc = 0, v;
    for (int ky = 0; ky < 3; ky++)
      for (int kx = 0; kx < 3; kx++) begin
        longint p = longint'($signed(mem[IN_B + c*size*size + (oy*s+ky)*size + ox*s+kx][15:0]));
        longint w = longint'($signed(mem[c*11 + ky*3 + kx][15:0]));
        acc += p * w;
      end
    v = sat(acc >>> 8);
    if (bn) v = sat(((v * longint'($signed(mem[c*11+9][15:0]))) >>> 8)
                    + longint'($signed(mem[c*11+10][15:0])));
    if (relu && v < 0) v = 0;
    return 32'(v);
  endfunction

  task automatic fill(input int seed);
    for (int a = 0; a < 1024; a++) mem[a] <= {16'hA5A5, 16'(((a*29 + seed*7) % 512) - 256)};
    for (int a = 1024; a < 2048; a++) mem[a] <= {16'h5A5A, 16'(((a*37 + seed*13) % 2048) - 1024)};
    for (int a = 4096; a < 8192; a++) mem[a] <= 32'hDEADBEEF;
    @(negedge clk);
  endtask

  task automatic kick(input int size, input int chan, input int sc, input bit bn, input bit relu);
    cfg_size = 8'(size); cfg_chan = 11'(chan); cfg_stride = 2'(sc);
    cfg_bn = bn; cfg_relu = relu; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 60000; i++) begin
      if (done) return;
      @(negedge clk);
    end
    total++; bad++;
    $display("FAIL R10 watchdog act=%h exp=%h", done, 1'b1);
  endtask

  task automatic verify(input string req, input int size, input int chan, input int sc,
                        input bit bn, input bit relu, input int wr0);
    int s = sc[1] ? 2 : 1;
    int o = (size - 3) / s + 1;
    for (int c = 0; c < chan; c++)
      for (int y = 0; y < o; y++)
        for (int x = 0; x < o; x++)
          chk(req, mem[OUT_B + c*o*o + y*o + x], model(c, y, x, size, s, bn, relu));
    chk("R7 write count", 32'(wr_cnt - wr0), 32'(chan*o*o));
  endtask

  initial begin
    #(CLK_NS * 190000);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=finished", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w0, r0;
    @(negedge clk);
    // R12
    chk("R12 busy", busy, 0); chk("R12 done", done, 0);
    chk("R12 rd_req", rd_req, 0); chk("R12 wr_req", wr_req, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int t = 0; t < 6; t++) begin
      int size = int'(VEC[t][31:24]), chan = int'(VEC[t][23:16]), sc = int'(VEC[t][15:12]);
      bit bn = VEC[t][8], relu = VEC[t][4];
      wmode = int'(VEC[t][3:0]); gmode = t % 2;
      fill(t + 1);
      w0 = wr_cnt;
      kick(size, chan, sc, bn, relu);
      chk("R10 busy after start", busy, 1);
      chk("R10 done cleared", done, 0);
      wait_done();
      verify("R1 R2 R3 R4 R5 R6 R7", size, chan, sc, bn, relu, w0);
      chk("R10 idle at done", busy, 0);
      repeat (5) @(negedge clk);
      chk("R10 done held", done, 1);
    end

    // R9: writes blocked, 16 results queued, reads stop
    wmode = 0; gmode = 1; fill(9); wr_hold = 1'b1;
    w0 = wr_cnt; r0 = rd_cnt;
    kick(10, 1, 0, 0, 0);
    repeat (3000) @(negedge clk);
    chk("R9 reads while full", 32'(rd_cnt - r0), 32'(11 + 9*16));
    chk("R9 no writes", 32'(wr_cnt - w0), 0);
    chk("R9 rd_req low", rd_req, 0);
    chk("R9 still busy", busy, 1);
    chk("R10 no early done", done, 0);
    wr_hold = 1'b0;
    wait_done();
    verify("R9 nothing lost", 10, 1, 0, 0, 0, w0);

    // R11: start during a run is ignored
    fill(12); w0 = wr_cnt;
    kick(6, 2, 0, 0, 0);
    repeat (40) @(negedge clk);
    kick(9, 5, 2, 1, 1);
    wait_done();
    verify("R11 original cfg", 6, 2, 0, 0, 0, w0);

    // R2 R5 R6: saturation, floor shift, batch-norm then ReLU
    for (int a = 0; a < 2048; a++) mem[a] <= 32'h0;
    for (int i = 0; i < 9; i++) begin
      mem[i] <= 32'h7FFF; mem[11+i] <= 32'h8000;
      mem[IN_B+i] <= 32'h7FFF; mem[IN_B+9+i] <= 32'h7FFF;
    end
    mem[9] <= 32'hFF00; mem[22] <= 32'h1; mem[31] <= 32'h100; mem[32] <= 32'h10;
    mem[33] <= 32'h1; mem[IN_B+18] <= 32'h1; mem[IN_B+27] <= 32'hFFFF;
    for (int a = 4096; a < 4104; a++) mem[a] <= 32'hDEADBEEF;
    @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      bit bn = m[1], relu = m[0];
      w0 = wr_cnt;
      kick(3, 4, 0, bn, relu);
      wait_done();
      if (!bn) begin
        chk("R2 saturate high", mem[OUT_B+0], 32'h00007FFF);
        chk("R2 R6 saturate low", mem[OUT_B+1], relu ? 32'h0 : 32'hFFFF8000);
        chk("R2 floor small", mem[OUT_B+2], 32'h0);
        chk("R2 R6 floor negative", mem[OUT_B+3], relu ? 32'h0 : 32'hFFFFFFFF);
      end else begin
        chk("R5 R6 scale then relu", mem[OUT_B+0], relu ? 32'h0 : 32'hFFFF8001);
        chk("R5 bias", mem[OUT_B+2], 32'h00000010);
      end
      verify("R2 R5 R6 model", 3, 4, 0, bn, relu, w0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule